// File: doc/BRIEF.md
# Bit-Mask Opcode Slot Sequencer

This block feeds a compressed execution mode. Software first fills an eight-entry opcode template through a configuration port while the mode is idle. A pulse on `enter` switches the block into the mode and selects one of two word formats. Each word that then arrives on the mask handshake is a set of enable bits. Every enable bit stands for one fixed template entry, and the block hands the enabled opcodes to the downstream executor one at a time.

In the mirrored format, the low seven enable bits run template entries 0 to 6 upward. The next bit runs entry 7 once. The seven bits above it run entries 6 down to 0. The top bit tells the block to leave the mode once the word is done. In the operand format, the low byte enables entries 0 to 7. The high byte is an operand that travels with every opcode issued from that word. A word whose enable byte is zero ends the mode. Cleared bits cost no cycles, because a priority encoder jumps straight to the next set bit.

Top module: `mask_slot_seq`

## Requirements
- R1: After reset, `active`, `iss_valid` and `mask_ready` are all 0.
- R2: A write on `cfg_we` while `active` is 0 stores `cfg_op` into entry `cfg_idx`. A write while `active` is 1 is ignored and leaves the stored entry unchanged.
- R3: A pulse on `enter` while inactive sets `active`. The format is latched from `enter_fmt`: 0 selects mirrored and 1 selects operand. While active with no word in progress, `mask_ready` is 1, and `iss_valid` is only ever 1 while `active` is 1.
- R4: In mirrored format, set bits are issued from bit 0 upward. Bit b in 0..6 issues entry b, bit 7 issues entry 7, and bit b in 8..14 issues entry 14-b.
- R5: Only set bits are issued, each exactly once. With `iss_ready` held high, a word with k set enable bits keeps `mask_ready` low for exactly k cycles after the cycle it is accepted.
- R6: In mirrored format, bit 15 set makes `active` fall once the last opcode of the word is accepted, or right after acceptance if no enable bit is set. With bit 15 clear, the block stays active and takes the next word with the same template.
- R7: A word with no enable bits that does not exit is finished in its accept cycle, and `mask_ready` is 1 again in the next cycle.
- R8: In operand format, bits 7:0 enable entries 0..7 from the lowest bit up, and bits 15:8 appear on `iss_arg` with every opcode of that word. In mirrored format, `iss_arg` is 0.
- R9: In operand format, a word whose bits 7:0 are all zero makes the block leave the mode, whatever its high byte holds.
- R10: While `iss_valid` is 1 and `iss_ready` is 0, `iss_valid`, `iss_op` and `iss_arg` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Template write strobe |
| cfg_idx | input | 3 | Template entry index |
| cfg_op | input | OP_W | Opcode to store |
| enter | input | 1 | Enter the mask mode |
| enter_fmt | input | 1 | Format at entry: 0 mirrored, 1 operand |
| mask_valid | input | 1 | Mask word offered |
| mask_word | input | 16 | Mask word |
| mask_ready | output | 1 | Block takes a mask word |
| iss_ready | input | 1 | Executor takes the issued opcode |
| iss_valid | output | 1 | Opcode on issue port is valid |
| iss_op | output | OP_W | Issued opcode |
| iss_arg | output | 8 | Operand shared by the word's opcodes |
| active | output | 1 | Mask mode in effect |

## Verification
On every cycle, the assertions check the following:
- issue outputs are held through a stall;
- exactly one enable bit is retired per accepted issue;
- the template is locked while the mode is in effect;
- an empty non-exit word gives the ready signal back a cycle later;
- issue never happens outside the mode.

Only the bench scenarios can show the rest:
- the opcode order of the mirrored mapping;
- the operand riding along in the second format;
- the exit rules of both formats;
- the cycle count proving that cleared bits cost nothing.

These are checked against a queue-based model.

// File: rtl/mask_slot_seq.sv
module mask_slot_seq #(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_idx,
  input  logic [OP_W-1:0] cfg_op,
  input  logic            enter,
  input  logic            enter_fmt,
  input  logic            mask_valid,
  input  logic [15:0]     mask_word,
  output logic            mask_ready,
  input  logic            iss_ready,
  output logic            iss_valid,
  output logic [OP_W-1:0] iss_op,
  output logic [7:0]      iss_arg,
  output logic            active
);
  localparam int NENT = 8;
  localparam int PW   = 15;

  logic [NENT-1:0][OP_W-1:0] tbl;
  logic          fmt, busy, exit_f;
  logic [PW-1:0] pend, pend_nx, wbits;
  logic [7:0]    arg;
  logic          wexit;
  logic [3:0]    lo;
  logic [2:0]    ent;

  assign wbits      = fmt ? {7'd0, mask_word[7:0]} : mask_word[14:0];
  assign wexit      = fmt ? (mask_word[7:0] == 8'd0) : mask_word[15];
  assign mask_ready = active && !busy;
  assign iss_valid  = busy;
  assign pend_nx    = pend & (pend - 1'b1);

  always_comb begin
    lo = 4'd0;
    for (int i = PW - 1; i >= 0; i--)
      if (pend[i]) lo = 4'(i);
  end

  always_comb begin
    if (fmt || lo <= 4'd7) ent = lo[2:0];
    else                   ent = 3'(4'd14 - lo);
  end

  assign iss_op  = tbl[ent];
  assign iss_arg = arg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl    <= '0;
      active <= 1'b0;
      fmt    <= 1'b0;
      busy   <= 1'b0;
      exit_f <= 1'b0;
      pend   <= '0;
      arg    <= '0;
    end else begin
      if (cfg_we && !active) tbl[cfg_idx] <= cfg_op;
      if (enter && !active) begin
        active <= 1'b1;
        fmt    <= enter_fmt;
      end
      if (mask_valid && mask_ready) begin
        pend   <= wbits;
        exit_f <= wexit;
        arg    <= fmt ? mask_word[15:8] : 8'd0;
        if (wbits != '0)  busy   <= 1'b1;
        else if (wexit)   active <= 1'b0;
      end
      if (iss_valid && iss_ready) begin
        pend <= pend_nx;
        if (pend_nx == '0) begin
          busy <= 1'b0;
          if (exit_f) active <= 1'b0;
        end
      end
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_op) && $stable(iss_arg));
  p_one_per_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready |=> $countones(pend) == $countones($past(pend)) - 1);
  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(tbl));
  p_zero_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid && mask_ready && wbits == '0 && !wexit |=> mask_ready);
  p_issue_in_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> active);
  p_exit_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && exit_f && $countones(pend) == 1 |=> !active);
endmodule

// File: tb/mask_slot_seq_tb.sv
module mask_slot_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, enter = 0, enter_fmt = 0, mask_valid = 0, iss_ready = 1;
  logic [2:0] cfg_idx = 0;
  logic [15:0] cfg_op = 0, mask_word = 0, iss_op;
  logic [7:0] iss_arg;
  logic mask_ready, iss_valid, active;

  mask_slot_seq dut_i (.clk, .rst_n, .cfg_we, .cfg_idx, .cfg_op, .enter, .enter_fmt,
    .mask_valid, .mask_word, .mask_ready, .iss_ready, .iss_valid, .iss_op, .iss_arg, .active);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] mtab [8];
  logic [15:0] q_op [$];
  logic [7:0]  q_arg [$];
  bit stall_en = 0, fmt_m = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  always @(negedge clk) iss_ready <= stall_en ? 1'($urandom % 2) : 1'b1;

  bit pv = 0, pr = 1;
  logic [15:0] pop;
  logic [7:0] parg;
  always begin
    @(negedge clk); #3;
    if (rst_n) begin
      if (pv && !pr)
        chk(iss_valid && iss_op == pop && iss_arg == parg, "R10 stall hold", iss_op, pop);
      if (iss_valid && iss_ready) begin
        if (q_op.size() == 0) chk(0, "R5 unexpected issue", iss_op, 0);
        else begin
          logic [15:0] eo;
          logic [7:0]  ea;
          eo = q_op.pop_front();
          ea = q_arg.pop_front();
          chk(iss_op == eo, fmt_m ? "R8 operand-format opcode" : "R4 mirrored order", iss_op, eo);
          chk(iss_arg == ea, "R8 shared operand", iss_arg, ea);
        end
      end
      pv = iss_valid; pr = iss_ready; pop = iss_op; parg = iss_arg;
    end
  end

  function automatic int ent_of(bit f, int b);
    if (f || b <= 7) return b;
    return 14 - b;
  endfunction

  task automatic cfg_write(input int idx, input logic [15:0] v, input bit take);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_op = v;
    if (take) mtab[idx] = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_enter(input bit f);
    @(negedge clk);
    enter = 1; enter_fmt = f; fmt_m = f;
    @(negedge clk);
    enter = 0;
    #3 chk(active && mask_ready, "R3 enter", {active, mask_ready}, 2'b11);
  endtask

  task automatic send_word(input logic [15:0] w, output int lows);
    int nb;
    bit acc;
    nb = fmt_m ? 8 : 15;
    for (int b = 0; b < nb; b++)
      if (w[b]) begin
        q_op.push_back(mtab[ent_of(fmt_m, b)]);
        q_arg.push_back(fmt_m ? w[15:8] : 8'd0);
      end
    @(negedge clk);
    mask_valid = 1; mask_word = w;
    do begin
      #3 acc = mask_ready;
      @(negedge clk);
    end while (!acc);
    mask_valid = 0;
    lows = 0;
    forever begin
      #3;
      if (mask_ready || !active) break;
      lows++;
      @(negedge clk);
    end
  endtask

  initial begin
    int l;
    repeat (3) @(negedge clk);
    #3 chk(!active && !iss_valid && !mask_ready, "R1 reset state",
           {active, iss_valid, mask_ready}, 0);
    rst_n = 1;
    for (int k = 0; k < 8; k++) cfg_write(k, 16'hA000 + 16'(k * 'h111), 1);

    do_enter(0);
    send_word(16'h0081, l);
    chk(l == 2, "R5 two bits two cycles", l, 2);
    send_word(16'h7FFF, l);
    chk(l == 15, "R5 full mirror no gaps", l, 15);
    chk(active, "R6 stays without exit bit", active, 1);
    send_word(16'h0000, l);
    chk(l == 0 && mask_ready, "R7 empty word", l, 0);
    send_word(16'h4103, l);
    chk(l == 4, "R4 mixed mirror", l, 4);
    cfg_write(0, 16'hBEEF, 0);
    send_word(16'h8001, l);
    chk(!active, "R6 exit after last issue", active, 0);
    chk(q_op.size() == 0, "R2 locked write ignored", q_op.size(), 0);

    cfg_write(0, 16'h1234, 1);
    do_enter(0);
    send_word(16'h0001, l);
    send_word(16'h8000, l);
    chk(!active && l == 0, "R6 exit with no bits", active, 0);
    chk(q_op.size() == 0, "R2 write while idle", q_op.size(), 0);

    do_enter(1);
    send_word(16'h5A05, l);
    chk(l == 2, "R8 operand word", l, 2);
    send_word(16'h33FF, l);
    stall_en = 1;
    send_word(16'hC3A5, l);
    send_word(16'h7E81, l);
    stall_en = 0;
    repeat (2) @(negedge clk);
    chk(active, "R9 nonzero mask stays", active, 1);
    send_word(16'h7700, l);
    chk(!active, "R9 zero mask byte exits", active, 0);

    do_enter(0);
    stall_en = 1;
    send_word(16'hFFFF, l);
    stall_en = 0;
    chk(!active, "R10 stalled exit word", active, 0);
    repeat (3) @(negedge clk);
    chk(q_op.size() == 0, "R5 every set bit issued", q_op.size(), 0);
    finish_run();
  end
endmodule